// File: doc/BRIEF.md
# Multithreaded Issue Slot Allocator

This block chooses, every clock cycle, up to eight instructions to issue from a shared instruction window. Up to eight hardware threads hold entries in that window, and all of them compete for the same issue slots in the same cycle. Each window entry presents a ready bit, the owning thread number, a wrapping age stamp, and two flags: one marks a branch and one marks a speculative or optimistic instruction. The allocator fills slot 0 first, then slot 1, and so on. For each slot it takes the best remaining eligible entry under the ordering policy that is selected.

Two controls shape the result. The first is a per-thread issue cap, which sets the most instructions one thread may take in a single cycle. The second is an ordering policy: plain oldest first, branches first, or speculative instructions last. The cap is applied while the slots are being filled. Once a thread has used up its allowance, the slots it cannot take go to the next eligible entries of other threads.

The slot results are captured in a register and presented one cycle after the inputs are sampled. Each slot has a valid bit, a window index and a one-hot grant vector. There is no ready signal back into the allocator. The downstream issue stage must accept every valid slot in the cycle it appears, and a new selection is made on every edge.

Top module: `issue_slot_alloc`

## Requirements
- R1: A slot only ever grants an entry whose ready bit was 1. The grant vector of a valid slot is one-hot, and its set bit is the window index the slot reports.
- R2: Under policy code 0 (and the spare code 3), slots are filled from slot 0 upward in increasing relative age. Relative age is computed as (age − head_age) modulo 2^(log2(depth)+1), so stamps that have wrapped past the head still count as younger.
- R3: Cap code 0, 1, 2 or 3 allows at most 1, 2, 4 or 8 grants to any one thread in a cycle. Code 3 means no per-thread limit.
- R4: No window entry is granted by more than one slot in the same cycle.
- R5: Valid slots are contiguous from slot 0. Each unused slot drives valid 0, index 0 and an all-zero grant vector.
- R6: Under policy code 1, every ready branch entry (branch flag 1) is placed ahead of all non-branch entries. Within each of those two groups the order is oldest first.
- R7: Under policy code 2, entries with the speculative flag set are placed only after every ready non-speculative entry. Within each of those two groups the order is oldest first.
- R8: The cap is enforced during filling. When a thread reaches its cap, its remaining ready entries are skipped, and lower-priority entries of other threads take the freed slots in the same cycle.
- R9: With a cap of 2, all eight slots fill when at least four threads each have two ready entries. With only three such threads, at most six slots fill.
- R10: Slot outputs change only on the clock edge after the inputs are applied. While reset is low, every slot's valid bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rdy_i | input | DEPTH (16) | Ready bit per window entry |
| tid_i | input | DEPTH*3 | Thread number per entry, entry e at bits [3e+2:3e] |
| age_i | input | DEPTH*5 | Age stamp per entry, entry e at bits [5e+4:5e] |
| brn_i | input | DEPTH | Branch flag per entry |
| spec_i | input | DEPTH | Speculative flag per entry |
| head_age_i | input | 5 | Age stamp of the oldest entry in the window |
| cap_sel_i | input | 2 | Per-thread cap code (0:1, 1:2, 2:4, 3:8) |
| policy_i | input | 2 | Ordering policy (0 oldest, 1 branch first, 2 speculative last, 3 as 0) |
| slot_vld_o | output | SLOTS (8) | Valid bit per issue slot |
| slot_idx_o | output | SLOTS*4 | Window index per slot, slot s at bits [4s+3:4s] |
| slot_gnt_o | output | SLOTS*DEPTH | One-hot grant vector per slot, slot s at bits [16s+15:16s] |

## Verification
The hardest situation to reach is a thread that hits its cap partway through filling. That forces a younger or lower-class entry of another thread into a slot that an older entry of the capped thread would otherwise have taken. To produce it, the stimulus loads one thread with six of the sixteen entries, including its two branch entries, and combines the lowest cap with the branch-first policy. Further table rows place the head stamp in the middle of the window, so that the oldest entries sit at high indices and the stamps of the low indices have wrapped. Other rows use a cap of 2 with ready entries spread over exactly three threads and then exactly four threads, to show where a full issue cycle becomes possible.

// File: rtl/issue_slot_alloc_pkg.sv
package issue_slot_alloc_pkg;
  typedef enum logic [1:0] {
    POL_OLDEST   = 2'd0,
    POL_BRANCH   = 2'd1,
    POL_SPECLAST = 2'd2,
    POL_SPARE    = 2'd3
  } issue_pol_e;
endpackage

// File: rtl/issue_slot_rank.sv
// Builds the sort key of one window entry: lower key issues first.
module issue_slot_rank
  import issue_slot_alloc_pkg::*;
#(
  parameter int AGE_W = 5,
  parameter int IDX_W = 4,
  parameter int IDX   = 0,
  localparam int KW   = 1 + AGE_W + IDX_W
) (
  input  logic [AGE_W-1:0] age,
  input  logic [AGE_W-1:0] head_age,
  input  logic             is_brn,
  input  logic             is_spec,
  input  logic [1:0]       policy,
  output logic [KW-1:0]    key
);
  logic             late_class;
  logic [AGE_W-1:0] rel_age;

  always_comb begin
    case (issue_pol_e'(policy))
      POL_BRANCH:   late_class = ~is_brn;
      POL_SPECLAST: late_class = is_spec;
      default:      late_class = 1'b0;
    endcase
    rel_age = age - head_age;
    key     = {late_class, rel_age, IDX_W'(IDX)};
  end
endmodule

// File: rtl/issue_slot_pick.sv
// Finds the eligible entry with the smallest key.
module issue_slot_pick #(
  parameter int N  = 16,
  parameter int KW = 10,
  parameter int IW = 4
) (
  input  logic [N-1:0]    elig,
  input  logic [N*KW-1:0] keys,
  output logic            found,
  output logic [IW-1:0]   idx
);
  logic [KW-1:0] best;

  always_comb begin
    found = 1'b0;
    best  = '1;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!found || keys[i*KW +: KW] < best)) begin
        found = 1'b1;
        best  = keys[i*KW +: KW];
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/issue_slot_alloc.sv
module issue_slot_alloc #(
  parameter int DEPTH   = 16,
  parameter int THREADS = 8,
  parameter int SLOTS   = 8,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int TID_W  = $clog2(THREADS),
  localparam int AGE_W  = IDX_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [DEPTH-1:0]       rdy_i,
  input  logic [DEPTH*TID_W-1:0] tid_i,
  input  logic [DEPTH*AGE_W-1:0] age_i,
  input  logic [DEPTH-1:0]       brn_i,
  input  logic [DEPTH-1:0]       spec_i,
  input  logic [AGE_W-1:0]       head_age_i,
  input  logic [1:0]             cap_sel_i,
  input  logic [1:0]             policy_i,
  output logic [SLOTS-1:0]       slot_vld_o,
  output logic [SLOTS*IDX_W-1:0] slot_idx_o,
  output logic [SLOTS*DEPTH-1:0] slot_gnt_o
);
  localparam int KW    = 1 + AGE_W + IDX_W;
  localparam int CNT_W = $clog2(SLOTS) + 1;

  logic [DEPTH*KW-1:0] keys;
  logic [CNT_W-1:0]    cap_lim;
  logic [DEPTH-1:0]    taken [SLOTS+1];
  logic [CNT_W-1:0]    cnt   [SLOTS+1][THREADS];
  logic [SLOTS-1:0]       nxt_vld;
  logic [SLOTS*IDX_W-1:0] nxt_idx;
  logic [SLOTS*DEPTH-1:0] nxt_gnt;

  assign cap_lim  = CNT_W'(1) << cap_sel_i;
  assign taken[0] = '0;

  for (genvar e = 0; e < DEPTH; e++) begin : g_rank
    issue_slot_rank #(.AGE_W(AGE_W), .IDX_W(IDX_W), .IDX(e)) u_rank (
      .age      (age_i[e*AGE_W +: AGE_W]),
      .head_age (head_age_i),
      .is_brn   (brn_i[e]),
      .is_spec  (spec_i[e]),
      .policy   (policy_i),
      .key      (keys[e*KW +: KW])
    );
  end

  for (genvar t = 0; t < THREADS; t++) begin : g_cnt0
    assign cnt[0][t] = '0;
  end

  // Slot chain: each slot sees the grants and thread counts of the slots before it.
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [DEPTH-1:0] elig;
    logic             found;
    logic [IDX_W-1:0] pidx;
    logic [TID_W-1:0] win_tid;

    for (genvar e = 0; e < DEPTH; e++) begin : g_elig
      assign elig[e] = rdy_i[e] & ~taken[s][e]
                     & (cnt[s][tid_i[e*TID_W +: TID_W]] < cap_lim);
    end

    issue_slot_pick #(.N(DEPTH), .KW(KW), .IW(IDX_W)) u_pick (
      .elig  (elig),
      .keys  (keys),
      .found (found),
      .idx   (pidx)
    );

    assign win_tid    = tid_i[pidx*TID_W +: TID_W];
    assign taken[s+1] = taken[s] | (found ? (DEPTH'(1) << pidx) : DEPTH'(0));

    for (genvar t = 0; t < THREADS; t++) begin : g_cnt
      assign cnt[s+1][t] = cnt[s][t] + CNT_W'(found && (win_tid == TID_W'(t)));
    end

    assign nxt_vld[s]                 = found;
    assign nxt_idx[s*IDX_W +: IDX_W]  = found ? pidx : '0;
    assign nxt_gnt[s*DEPTH +: DEPTH]  = found ? (DEPTH'(1) << pidx) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_vld_o <= '0;
      slot_idx_o <= '0;
      slot_gnt_o <= '0;
    end else begin
      slot_vld_o <= nxt_vld;
      slot_idx_o <= nxt_idx;
      slot_gnt_o <= nxt_gnt;
    end
  end
endmodule

// File: rtl/issue_slot_alloc_chk.sv
module issue_slot_alloc_chk #(
  parameter int DEPTH   = 16,
  parameter int THREADS = 8,
  parameter int SLOTS   = 8,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int TID_W  = $clog2(THREADS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [DEPTH-1:0]       rdy_i,
  input logic [DEPTH*TID_W-1:0] tid_i,
  input logic [1:0]             cap_sel_i,
  input logic [SLOTS-1:0]       slot_vld_o,
  input logic [SLOTS*IDX_W-1:0] slot_idx_o,
  input logic [SLOTS*DEPTH-1:0] slot_gnt_o
);
  logic [DEPTH-1:0]       rdy_q;
  logic [DEPTH*TID_W-1:0] tid_q;
  logic [1:0]             cap_q;
  logic                   dup_hit, cap_hit, bad_gnt, stray_gnt, hole;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= '0;
      tid_q <= '0;
      cap_q <= '0;
    end else begin
      rdy_q <= rdy_i;
      tid_q <= tid_i;
      cap_q <= cap_sel_i;
    end
  end

  always_comb begin
    logic [DEPTH-1:0] seen;
    int               per_thr [THREADS];
    dup_hit = 1'b0;
    cap_hit = 1'b0;
    bad_gnt = 1'b0;
    hole    = 1'b0;
    seen    = '0;
    for (int t = 0; t < THREADS; t++) per_thr[t] = 0;
    for (int s = 0; s < SLOTS; s++) begin
      if (slot_vld_o[s]) begin
        if (slot_gnt_o[s*DEPTH +: DEPTH] != (DEPTH'(1) << slot_idx_o[s*IDX_W +: IDX_W]))
          bad_gnt = 1'b1;
        if ((seen & slot_gnt_o[s*DEPTH +: DEPTH]) != '0) dup_hit = 1'b1;
        seen = seen | slot_gnt_o[s*DEPTH +: DEPTH];
        per_thr[tid_q[slot_idx_o[s*IDX_W +: IDX_W]*TID_W +: TID_W]]++;
      end else if (slot_gnt_o[s*DEPTH +: DEPTH] != '0) begin
        bad_gnt = 1'b1;
      end
      if (s > 0 && slot_vld_o[s] && !slot_vld_o[s-1]) hole = 1'b1;
    end
    for (int t = 0; t < THREADS; t++)
      if (per_thr[t] > (1 << cap_q)) cap_hit = 1'b1;
    stray_gnt = (seen & ~rdy_q) != '0;
  end

  assert_ready_only_R1:  assert property (@(posedge clk) disable iff (!rst_n) !stray_gnt);
  assert_gnt_onehot_R1:  assert property (@(posedge clk) disable iff (!rst_n) !bad_gnt);
  assert_thread_cap_R3:  assert property (@(posedge clk) disable iff (!rst_n) !cap_hit);
  assert_single_use_R4:  assert property (@(posedge clk) disable iff (!rst_n) !dup_hit);
  assert_no_hole_R5:     assert property (@(posedge clk) disable iff (!rst_n) !hole);
endmodule

bind issue_slot_alloc issue_slot_alloc_chk #(
  .DEPTH(DEPTH), .THREADS(THREADS), .SLOTS(SLOTS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rdy_i      (rdy_i),
  .tid_i      (tid_i),
  .cap_sel_i  (cap_sel_i),
  .slot_vld_o (slot_vld_o),
  .slot_idx_o (slot_idx_o),
  .slot_gnt_o (slot_gnt_o)
);

// File: tb/issue_slot_alloc_test.sv
module issue_slot_alloc_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [15:0]  rdy_i = '0, brn_i = '0, spec_i = '0;
  logic [47:0]  tid_i;
  logic [79:0]  age_i;
  logic [4:0]   head_age_i = '0;
  logic [1:0]   cap_sel_i = '0, policy_i = '0;
  logic [7:0]   slot_vld_o;
  logic [31:0]  slot_idx_o;
  logic [127:0] slot_gnt_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  issue_slot_alloc uut (
    .clk(clk), .rst_n(rst_n), .rdy_i(rdy_i), .tid_i(tid_i), .age_i(age_i),
    .brn_i(brn_i), .spec_i(spec_i), .head_age_i(head_age_i),
    .cap_sel_i(cap_sel_i), .policy_i(policy_i),
    .slot_vld_o(slot_vld_o), .slot_idx_o(slot_idx_o), .slot_gnt_o(slot_gnt_o)
  );

  // Entries 0-5 belong to thread 0; entries 6..15 pair up into threads 1..5. Age of entry e is e.
  initial begin
    for (int e = 0; e < 16; e++) begin
      tid_i[e*3 +: 3] = (e < 6) ? 3'd0 : 3'(((e - 6) >> 1) + 1);
      age_i[e*5 +: 5] = 5'(e);
    end
  end

  typedef struct packed {
    logic [15:0] rdy;
    logic [15:0] brn;
    logic [15:0] spec;
    logic [4:0]  head;
    logic [1:0]  cap;
    logic [1:0]  pol;
    logic [7:0]  ev;
    logic [31:0] ei;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{16'hFFFF, 16'h0000, 16'h0000, 5'd0,  2'd3, 2'd0, 8'hFF, 32'h76543210}, // R2 oldest first
    '{16'hFFFF, 16'h0000, 16'h0000, 5'd0,  2'd0, 2'd0, 8'h3F, 32'h00ECA860}, // R3 cap 1, R5 partial
    '{16'hFFFF, 16'h0000, 16'h0000, 5'd0,  2'd1, 2'd0, 8'hFF, 32'hBA987610}, // R3 cap 2
    '{16'hFFFF, 16'h0000, 16'h0000, 5'd0,  2'd2, 2'd0, 8'hFF, 32'h98763210}, // R3 cap 4
    '{16'h000F, 16'h0000, 16'h0000, 5'd0,  2'd0, 2'd0, 8'h01, 32'h00000000}, // R3 R5 single thread
    '{16'hFFFF, 16'h0000, 16'h0000, 5'd10, 2'd3, 2'd3, 8'hFF, 32'h10FEDCBA}, // R2 wrapped stamps
    '{16'hFFFF, 16'h1020, 16'h0000, 5'd0,  2'd3, 2'd1, 8'hFF, 32'h643210C5}, // R6 branch first
    '{16'hFFFF, 16'h0000, 16'h003F, 5'd0,  2'd3, 2'd2, 8'hFF, 32'hDCBA9876}, // R7 speculative last
    '{16'h00C3, 16'h0000, 16'h0003, 5'd0,  2'd3, 2'd2, 8'h0F, 32'h00001076}, // R7 R5 spec fills tail
    '{16'h0FC0, 16'h0000, 16'h0000, 5'd0,  2'd1, 2'd0, 8'h3F, 32'h00BA9876}, // R9 three threads
    '{16'h3FC0, 16'h0000, 16'h0000, 5'd0,  2'd1, 2'd0, 8'hFF, 32'hDCBA9876}, // R9 four threads
    '{16'hFFFF, 16'h0024, 16'h0000, 5'd0,  2'd0, 2'd1, 8'h3F, 32'h00ECA862}  // R8 cap during fill
  };

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] exp_gnt(input logic [7:0] ev, input logic [31:0] ei);
    logic [127:0] g = '0;
    for (int s = 0; s < 8; s++)
      if (ev[s]) g[s*16 + int'(ei[s*4 +: 4])] = 1'b1;
    return g;
  endfunction

  initial begin
    rdy_i = 16'hFFFF;
    repeat (3) @(negedge clk);
    check("R10 valid low in reset", 128'(slot_vld_o), 128'h0);
    rst_n = 1'b1;
    rdy_i = '0;
    @(negedge clk);
    check("R5 nothing ready", 128'(slot_vld_o), 128'h0);
    check("R5 idle grants zero", slot_gnt_o, 128'h0);

    for (int i = 0; i < NV; i++) begin
      rdy_i = TBL[i].rdy; brn_i = TBL[i].brn; spec_i = TBL[i].spec;
      head_age_i = TBL[i].head; cap_sel_i = TBL[i].cap; policy_i = TBL[i].pol;
      @(negedge clk);
      $display("row %0d", i);
      check("R2 R3 R5 R6 R7 R8 R9 slot valid", 128'(slot_vld_o), 128'(TBL[i].ev));
      check("R2 R3 R6 R7 R8 R9 slot index", 128'(slot_idx_o), 128'(TBL[i].ei));
      check("R1 R4 R5 grant vectors", slot_gnt_o, exp_gnt(TBL[i].ev, TBL[i].ei));
    end

    // R10: one cycle of latency from inputs to slot outputs
    rdy_i = '0;
    @(negedge clk);
    rdy_i = 16'hFFFF; brn_i = '0; spec_i = '0; head_age_i = '0;
    cap_sel_i = 2'd3; policy_i = 2'd0;
    #1;
    check("R10 no change before edge", 128'(slot_vld_o), 128'h0);
    @(negedge clk);
    check("R10 result after edge", 128'(slot_idx_o), 128'h76543210);
    rst_n = 1'b0;
    #1;
    check("R10 reset clears valid", 128'(slot_vld_o), 128'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 50000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule